// File: doc/BRIEF.md
# Host Interrupt Mask and Status Controller

This block gathers single-cycle event pulses from the blocks inside a wireless MAC into one host interrupt line. Each event sets a sticky status bit. The bit stays set until the host clears it. A per-bit mask decides which active status bits may assert the host line. A 1 in the mask blocks that source and a 0 lets it through.

The host reaches the block over a simple register bus with a single-cycle write strobe and read strobe, and read data returned in the same cycle. It can read and write the whole mask, or set and clear chosen mask bits through two write-only alias addresses. It can read the status in two ways: a peek that leaves the status alone, or a take that returns the status and then empties it. It can also acknowledge chosen status bits by writing ones. Only certain bit positions carry a source. All other positions are reserved.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x00001, both status views read 0, and `host_irq` is deasserted (0 with the default high-active polarity).
- R2: A pulse on `src_evt[i]` for an implemented bit i sets status bit i. The bit stays set until an acknowledge or a take read clears it. Implemented bits are 0 to 10, 14, 16 and 17. The pulse at index i is reported at status bit i and is gated by mask bit i.
- R3: A write to address 0 loads the mask, and a read of address 0 returns it.
- R4: A write to address 1 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R5: A write to address 2 clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status as it was before the read. After that clock edge all status bits are 0.
- R8: A write to address 5 clears each status bit whose write-data bit is 1. The cleared bits show as 0 in both status views. Bits written as 0 are not affected.
- R9: If an event arrives in the same cycle that its status bit is cleared by an acknowledge or a take read, the status bit ends up set.
- R10: `host_irq` is asserted when any status bit is set while its mask bit is 0. It is a register, so it changes on the clock edge after the status or mask change becomes visible. A status bit whose mask bit is 1 does not assert it.
- R11: Reserved bit positions always read as 0 in the mask and in the status, and writes and events at those positions are ignored. Reads of the write-only addresses 1, 2 and 5, and of unused addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 18 | Event pulses, one per interrupt bit position |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 18 | Write data |
| bus_rdata | output | 18 | Read data, valid in the cycle of `bus_rd` |
| host_irq | output | 1 | Host interrupt line |

## Verification
The hardest case to reach from the ports is a race: an event pulse lands in exactly the cycle in which the host clears that same status bit. The clear can come from an acknowledge write or from a take read. The bench drives `src_evt` and the bus strobe from the same task call so that they share one clock edge. It then peeks at the status to confirm that the bit survived. In the take-read race it also confirms that the read returned the status from before the clear. The one-cycle lag of the interrupt line is sampled on both sides of the register edge, for a status change and for a mask change.

// File: rtl/hint_pkg.sv
package hint_pkg;
   localparam int HINT_ADDR_W = 3;

   typedef enum logic [HINT_ADDR_W-1:0] {
      HR_MASK     = 3'd0,
      HR_MASK_SET = 3'd1,
      HR_MASK_CLR = 3'd2,
      HR_STS_PEEK = 3'd3,
      HR_STS_TAKE = 3'd4,
      HR_ACK      = 3'd5
   } hreg_e;

   localparam int          HINT_NUM_SRC  = 18;
   localparam logic [31:0] HINT_IMPL_MAP = 32'h0003_47FF;
   localparam logic [31:0] HINT_MASK_RST = 32'h0000_0001;
endpackage

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
   parameter int          W       = 18,
   parameter logic [31:0] IMPL    = 32'h0003_47FF,
   parameter logic [31:0] RST_VAL = 32'h0000_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_full,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);
   localparam logic [W-1:0] IMPL_W = IMPL[W-1:0];
   localparam logic [W-1:0] RST_W  = RST_VAL[W-1:0];

   if ((RST_VAL[W-1:0] & ~IMPL[W-1:0]) != '0) begin : g_bad_rst
      $error("mask reset value touches reserved bits");
   end

   logic [W-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (wr_full)     mask_d = wdata & IMPL_W;
      else if (wr_set) mask_d = mask_q | (wdata & IMPL_W);
      else if (wr_clr) mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= RST_W;
      else        mask_q <= mask_d;
   end

   p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((mask_q & $past(wdata & IMPL_W)) == $past(wdata & IMPL_W)))
      else $error("mask set alias failed");

   p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((mask_q & $past(wdata)) == '0))
      else $error("mask clear alias failed");

   p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_full && !wr_set && !wr_clr) |=> $stable(mask_q))
      else $error("mask changed without a write");
endmodule

// File: rtl/hint_status_reg.sv
module hint_status_reg #(
   parameter int          W    = 18,
   parameter logic [31:0] IMPL = 32'h0003_47FF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr,
   output logic [W-1:0] sts_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sts_q[i] <= 1'b0;
            else        sts_q[i] <= evt[i] | (sts_q[i] & ~clr[i]);
         end

         p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !clr[i]) |=> sts_q[i])
            else $error("status bit %0d lost", i);

         p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> sts_q[i])
            else $error("event on bit %0d not latched", i);

         p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !sts_q[i])
            else $error("status bit %0d not cleared", i);
      end else begin : g_rsvd
         assign sts_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/hint_irq_drive.sv
module hint_irq_drive #(
   parameter int W          = 18,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sts,
   input  logic [W-1:0] mask,
   output logic         irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(sts & ~mask);
   end

   if (ACTIVE_LOW) begin : g_low
      assign irq_o = ~irq_q;
   end else begin : g_high
      assign irq_o = irq_q;
   end

   p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts & ~mask)) |=> (irq_o == !ACTIVE_LOW))
      else $error("host irq missed an unmasked status");

   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sts & ~mask)) |=> (irq_o == ACTIVE_LOW))
      else $error("host irq asserted with nothing pending");
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
   import hint_pkg::*;
#(
   parameter int          NUM_SRC    = HINT_NUM_SRC,
   parameter logic [31:0] IMPL_MAP   = HINT_IMPL_MAP,
   parameter logic [31:0] MASK_RST   = HINT_MASK_RST,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SRC-1:0]     src_evt,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [HINT_ADDR_W-1:0] bus_addr,
   input  logic [NUM_SRC-1:0]     bus_wdata,
   output logic [NUM_SRC-1:0]     bus_rdata,
   output logic                   host_irq
);
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_width
      $error("NUM_SRC must lie in 1..32");
   end

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] sts_q;
   logic [NUM_SRC-1:0] sts_clr;
   logic               wr_full, wr_set, wr_clr, wr_ack, rd_take;

   assign wr_full = bus_wr && (bus_addr == HR_MASK);
   assign wr_set  = bus_wr && (bus_addr == HR_MASK_SET);
   assign wr_clr  = bus_wr && (bus_addr == HR_MASK_CLR);
   assign wr_ack  = bus_wr && (bus_addr == HR_ACK);
   assign rd_take = bus_rd && (bus_addr == HR_STS_TAKE);

   assign sts_clr = (wr_ack ? bus_wdata : '0) | {NUM_SRC{rd_take}};

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            HR_MASK:     bus_rdata = mask_q;
            HR_STS_PEEK: bus_rdata = sts_q;
            HR_STS_TAKE: bus_rdata = sts_q;
            default:     bus_rdata = '0;
         endcase
      end
   end

   hint_mask_reg #(.W(NUM_SRC), .IMPL(IMPL_MAP), .RST_VAL(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_full(wr_full), .wr_set(wr_set),
      .wr_clr(wr_clr), .wdata(bus_wdata), .mask_q(mask_q));

   hint_status_reg #(.W(NUM_SRC), .IMPL(IMPL_MAP)) u_sts (
      .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr(sts_clr), .sts_q(sts_q));

   hint_irq_drive #(.W(NUM_SRC), .ACTIVE_LOW(ACTIVE_LOW)) u_irq (
      .clk(clk), .rst_n(rst_n), .sts(sts_q), .mask(mask_q), .irq_o(host_irq));

   p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_take && !(|src_evt)) |=> (sts_q == '0))
      else $error("take read left status bits set");

   p_peek_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == HR_STS_PEEK && !bus_wr && !(|src_evt)) |=> $stable(sts_q))
      else $error("peek read changed status");
endmodule

// File: tb/host_irq_ctrl_tb_top.sv
module host_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 18;
   localparam logic [1:0] OP_NOP = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
   localparam logic [2:0] A_MASK = 3'd0, A_SET = 3'd1, A_CLR = 3'd2,
                          A_PEEK = 3'd3, A_TAKE = 3'd4, A_ACK = 3'd5;

   typedef struct packed {
      logic [1:0]   op;
      logic [2:0]   addr;
      logic [W-1:0] wdata;
      logic [W-1:0] evt;
      logic [W-1:0] exp;
      logic [3:0]   req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,  A_MASK, 18'h0,     18'h0,     18'h00001, 4'd1},  // R1
      '{OP_RD,  A_PEEK, 18'h0,     18'h0,     18'h00000, 4'd1},  // R1
      '{OP_WR,  A_MASK, 18'h3FFFF, 18'h0,     18'h0,     4'd3},
      '{OP_RD,  A_MASK, 18'h0,     18'h0,     18'h347FF, 4'd3},  // R3 R11
      '{OP_WR,  A_CLR,  18'h00F0F, 18'h0,     18'h0,     4'd5},
      '{OP_RD,  A_MASK, 18'h0,     18'h0,     18'h340F0, 4'd5},  // R5
      '{OP_WR,  A_SET,  18'h0B801, 18'h0,     18'h0,     4'd4},
      '{OP_RD,  A_MASK, 18'h0,     18'h0,     18'h340F1, 4'd4},  // R4 R11
      '{OP_NOP, A_MASK, 18'h0,     18'h0C005, 18'h0,     4'd2},
      '{OP_RD,  A_PEEK, 18'h0,     18'h0,     18'h04005, 4'd2},  // R2 R11
      '{OP_RD,  A_PEEK, 18'h0,     18'h0,     18'h04005, 4'd6},  // R6
      '{OP_WR,  A_ACK,  18'h00004, 18'h0,     18'h0,     4'd8},
      '{OP_RD,  A_PEEK, 18'h0,     18'h0,     18'h04001, 4'd8},  // R8
      '{OP_RD,  A_TAKE, 18'h0,     18'h0,     18'h04001, 4'd7},  // R7
      '{OP_RD,  A_PEEK, 18'h0,     18'h0,     18'h00000, 4'd7},  // R7
      '{OP_RD,  A_SET,  18'h0,     18'h0,     18'h00000, 4'd11}  // R11
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] src_evt = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         host_irq;
   int           checks = 0, errors = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   host_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .host_irq(host_irq));

   task automatic step(input logic [1:0] op, input logic [2:0] addr,
                       input logic [W-1:0] wd, input logic [W-1:0] ev);
      @(negedge clk);
      bus_wr    = (op == OP_WR);
      bus_rd    = (op == OP_RD);
      bus_addr  = addr;
      bus_wdata = wd;
      src_evt   = ev;
      #1;
   endtask

   task automatic check(input string req, input logic [W-1:0] got,
                        input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%05h expected 0x%05h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 irq after reset", {17'h0, host_irq}, 18'h0);

      for (int k = 0; k < NV; k++) begin
         step(VEC[k].op, VEC[k].addr, VEC[k].wdata, VEC[k].evt);
         if (VEC[k].op == OP_RD)
            check($sformatf("R%0d table step %0d", VEC[k].req, k), bus_rdata, VEC[k].exp);
      end

      // R10: unmasked bit 1, registered output lags status by one edge
      step(OP_NOP, A_MASK, '0, 18'h00002);
      step(OP_NOP, A_MASK, '0, '0);
      check("R10 irq before its edge", {17'h0, host_irq}, 18'h0);
      step(OP_NOP, A_MASK, '0, '0);
      check("R10 irq raised", {17'h0, host_irq}, 18'h1);
      step(OP_WR, A_ACK, 18'h00002, '0);
      step(OP_NOP, A_MASK, '0, '0);
      step(OP_NOP, A_MASK, '0, '0);
      check("R10 irq dropped after ack", {17'h0, host_irq}, 18'h0);

      // R10: masked bit 4 does not raise the line
      step(OP_NOP, A_MASK, '0, 18'h00010);
      step(OP_NOP, A_MASK, '0, '0);
      step(OP_RD, A_PEEK, '0, '0);
      check("R10 masked status present", bus_rdata, 18'h00010);
      check("R10 masked irq quiet", {17'h0, host_irq}, 18'h0);
      step(OP_WR, A_CLR, 18'h00010, '0);
      step(OP_NOP, A_MASK, '0, '0);
      check("R10 irq lags mask clear", {17'h0, host_irq}, 18'h0);
      step(OP_NOP, A_MASK, '0, '0);
      check("R10 irq after unmask", {17'h0, host_irq}, 18'h1);

      // R9: event racing an acknowledge, then a take read
      step(OP_WR, A_ACK, 18'h00010, 18'h00010);
      step(OP_RD, A_PEEK, '0, '0);
      check("R9 event beats ack", bus_rdata, 18'h00010);
      step(OP_RD, A_TAKE, '0, 18'h00004);
      check("R7 take returns old status", bus_rdata, 18'h00010);
      step(OP_RD, A_PEEK, '0, '0);
      check("R9 event beats take", bus_rdata, 18'h00004);

      step(OP_NOP, A_MASK, '0, '0);
      finish_run();
   end
endmodule